// File: doc/BRIEF.md
# Byte-Lane Static RAM Model with Dual Chip Select

This block is a synthesizable stand-in for an asynchronous 16-bit static RAM, sized down for simulation. It serves as the memory target when a memory controller is verified. Two chip selects gate access: one is active low and the other active high. Two active-low lane controls each enable one byte of the word. An active-low write strobe and an active-low output enable pick between writing, reading and idling.

The bidirectional data bus of a real part is split in two. There is a write-data input, a read-data output and one output-enable bit per byte lane, so a bench can see which lanes would drive the bus and which would float. Reads are combinational from the array. Writes are sampled on a fast internal clock. Every clock cycle in which the write condition holds stores the enabled lanes, so the value present in the last such cycle is the one kept.

The full-size part has an 18-bit address. The model keeps that port width and indexes its array with only the low log2(DEPTH) bits.

Top module: `sram_lane_model`

## Requirements
- R1: While `sel_lo_ni` is 1, `lane_oe_o` is 2'b00 and no lane is written.
- R2: While `sel_hi_i` is 0, `lane_oe_o` is 2'b00 and no lane is written.
- R3: While both `lane_lo_ni` and `lane_hi_ni` are 1, `lane_oe_o` is 2'b00 and no lane is written.
- R4: On a rising `clk_i` edge with `rst_ni`=1, `sel_lo_ni`=0, `sel_hi_i`=1 and `wr_ni`=0, each enabled lane of `wdata_i` is stored at the addressed word.
- R5: `lane_lo_ni`=0 enables the lower lane, bits 7:0, and `lane_hi_ni`=0 enables the upper lane, bits 15:8. A write leaves a disabled lane's stored byte unchanged.
- R6: With the chip selected, `wr_ni`=1 and `out_en_ni`=0, `lane_oe_o[0]` equals the inverse of `lane_lo_ni` and `lane_oe_o[1]` equals the inverse of `lane_hi_ni`. Each enabled lane of `rdata_o` shows the stored byte.
- R7: With `wr_ni`=1 and `out_en_ni`=1, `lane_oe_o` is 2'b00.
- R8: With `wr_ni`=0, `lane_oe_o` is 2'b00 whatever the value of `out_en_ni`.
- R9: Each byte of `rdata_o` whose `lane_oe_o` bit is 0 reads as 8'h00.
- R10: Only `addr_i[log2(DEPTH)-1:0]` selects the word. Addresses that differ only in higher bits reach the same word.
- R11: When a write is held over several clock cycles with changing data, the data of the last write cycle is the value kept.
- R12: While `rst_ni` is 0, `lane_oe_o` is 2'b00 and no write takes place. Stored contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock for writes |
| rst_ni | input | 1 | Asynchronous active-low reset; blocks drive and writes |
| sel_lo_ni | input | 1 | Active-low chip select |
| sel_hi_i | input | 1 | Active-high chip select |
| lane_lo_ni | input | 1 | Active-low enable of bits 7:0 |
| lane_hi_ni | input | 1 | Active-low enable of bits 15:8 |
| wr_ni | input | 1 | Active-low write strobe |
| out_en_ni | input | 1 | Active-low output enable |
| addr_i | input | ADDR_W (18) | Word address; low log2(DEPTH) bits used |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data; zero on undriven lanes |
| lane_oe_o | output | 2 | Per-lane drive enable; bit 0 lower, bit 1 upper |

## Verification
The assertions assume that the control, address and data inputs change only between clock edges and hold steady across each rising edge. The write readback property also assumes that a read of the same address follows in the very next cycle, which it checks only when that happens. The bench changes every input on the falling edge and samples one time unit later, so combinational read paths settle well before the next sampling edge. It also sweeps all 64 combinations of the six control inputs, giving each combination its own data word. A write that should not have happened therefore shows up when the memory is read back.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_READ  = 2'd2,
    MODE_WRITE = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_lane_pkg::*;
(
  input  logic             rst_ni,
  input  logic             sel_lo_ni,
  input  logic             sel_hi_i,
  input  logic [LANES-1:0] lane_ni,
  input  logic             wr_ni,
  input  logic             out_en_ni,
  output logic [LANES-1:0] wr_lane_o,
  output logic [LANES-1:0] rd_lane_o
);
  sram_mode_e mode;
  logic       chip_on;

  assign chip_on = rst_ni & ~sel_lo_ni & sel_hi_i & ~(&lane_ni);

  always_comb begin
    if (!chip_on)        mode = MODE_OFF;
    else if (!wr_ni)     mode = MODE_WRITE;
    else if (!out_en_ni) mode = MODE_READ;
    else                 mode = MODE_IDLE;
  end

  always_comb begin
    wr_lane_o = '0;
    rd_lane_o = '0;
    unique case (mode)
      MODE_WRITE: wr_lane_o = ~lane_ni;
      MODE_READ:  rd_lane_o = ~lane_ni;
      default: ;
    endcase
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_lane_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANES-1:0]  wr_lane_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] raw_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (wr_lane_i[l]) mem[idx_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign raw_o[l*LANE_W +: LANE_W] = mem[idx_i];
  end
endmodule

// File: rtl/sram_read_gate.sv
module sram_read_gate
  import sram_lane_pkg::*;
(
  input  logic [LANES-1:0]  rd_lane_i,
  input  logic [WORD_W-1:0] raw_i,
  output logic [LANES-1:0]  lane_oe_o,
  output logic [WORD_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_gate
    assign lane_oe_o[l] = rd_lane_i[l];
    assign rdata_o[l*LANE_W +: LANE_W] =
      rd_lane_i[l] ? raw_i[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_lane_pkg::*;
#(
  parameter int unsigned DEPTH  = 1024,
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_lo_ni,
  input  logic              sel_hi_i,
  input  logic              lane_lo_ni,
  input  logic              lane_hi_ni,
  input  logic              wr_ni,
  input  logic              out_en_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [1:0]        lane_oe_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LANES-1:0]  wr_lane, rd_lane;
  logic [WORD_W-1:0] raw;
  logic [IDX_W-1:0]  idx;

  assign idx = addr_i[IDX_W-1:0];

  if (ADDR_W > IDX_W) begin : g_hi_addr
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:IDX_W];
  end

  sram_mode_decode u_decode (
    .rst_ni    (rst_ni),
    .sel_lo_ni (sel_lo_ni),
    .sel_hi_i  (sel_hi_i),
    .lane_ni   ({lane_hi_ni, lane_lo_ni}),
    .wr_ni     (wr_ni),
    .out_en_ni (out_en_ni),
    .wr_lane_o (wr_lane),
    .rd_lane_o (rd_lane)
  );

  sram_lane_array #(.DEPTH(DEPTH)) u_array (
    .clk_i     (clk_i),
    .idx_i     (idx),
    .wr_lane_i (wr_lane),
    .wdata_i   (wdata_i),
    .raw_o     (raw)
  );

  sram_read_gate u_gate (
    .rd_lane_i (rd_lane),
    .raw_i     (raw),
    .lane_oe_o (lane_oe_o),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/sram_lane_model_chk.sv
module sram_lane_model_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_lo_ni,
  input logic              sel_hi_i,
  input logic              lane_lo_ni,
  input logic              lane_hi_ni,
  input logic              wr_ni,
  input logic              out_en_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic [1:0]        lane_oe_o
);
  logic sel_on, rd_mode, wr_mode;
  assign sel_on  = !sel_lo_ni && sel_hi_i;
  assign rd_mode = sel_on && wr_ni && !out_en_ni;
  assign wr_mode = sel_on && !wr_ni;

  assert_off_sel_lo_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_lo_ni |-> lane_oe_o == 2'b00);

  assert_off_sel_hi_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_hi_i |-> lane_oe_o == 2'b00);

  assert_off_lanes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_lo_ni && lane_hi_ni) |-> lane_oe_o == 2'b00);

  assert_read_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode |-> lane_oe_o == {!lane_hi_ni, !lane_lo_ni});

  assert_idle_float_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni && out_en_ni) |-> lane_oe_o == 2'b00);

  assert_write_float_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ni |-> lane_oe_o == 2'b00);

  assert_gate_lo_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o[0] |-> rdata_o[7:0] == 8'h00);

  assert_gate_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o[1] |-> rdata_o[15:8] == 8'h00);

  assert_write_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && !lane_lo_ni) |=>
      (!(rd_mode && !lane_lo_ni && addr_i == $past(addr_i))
       || rdata_o[7:0] == $past(wdata_i[7:0])));

  assert_write_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode && !lane_hi_ni) |=>
      (!(rd_mode && !lane_hi_ni && addr_i == $past(addr_i))
       || rdata_o[15:8] == $past(wdata_i[15:8])));
endmodule

bind sram_lane_model sram_lane_model_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sram_lane_model_tb.sv
module sram_lane_model_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int ADDR_W     = 18;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              sel_lo_ni, sel_hi_i, lane_lo_ni, lane_hi_ni, wr_ni, out_en_ni;
  logic [ADDR_W-1:0] addr_i;
  logic [15:0]       wdata_i;
  logic [15:0]       rdata_o;
  logic [1:0]        lane_oe_o;

  logic [15:0] exp_mem [DEPTH];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sram_lane_model #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                         input logic lo_n, input logic hi_n);
    @(negedge clk_i);
    sel_lo_ni = 0; sel_hi_i = 1; lane_lo_ni = lo_n; lane_hi_ni = hi_n;
    wr_ni = 0; out_en_ni = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    if (rst_ni) begin
      if (!lo_n) exp_mem[a % DEPTH][7:0]  = d[7:0];
      if (!hi_n) exp_mem[a % DEPTH][15:8] = d[15:8];
    end
    @(negedge clk_i);
    wr_ni = 1;
  endtask

  task automatic rd_word(input logic [ADDR_W-1:0] a, input logic lo_n,
                         input logic hi_n, input string tag);
    logic [15:0] e;
    @(negedge clk_i);
    sel_lo_ni = 0; sel_hi_i = 1; lane_lo_ni = lo_n; lane_hi_ni = hi_n;
    wr_ni = 1; out_en_ni = 0; addr_i = a;
    #1;
    e = exp_mem[a % DEPTH] & {{8{!hi_n}}, {8{!lo_n}}};
    chk({tag, " R6 oe"}, 32'(lane_oe_o), 32'({!hi_n, !lo_n}));
    chk({tag, " data"}, 32'(rdata_o), 32'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0;
    sel_lo_ni = 0; sel_hi_i = 1; lane_lo_ni = 0; lane_hi_ni = 0;
    wr_ni = 1; out_en_ni = 0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R12 reset oe", 32'(lane_oe_o), 0);
    chk("R9 reset data", 32'(rdata_o), 0);
    @(negedge clk_i);
    rst_ni = 1;

    // R4 fill every word with both lanes
    for (int a = 0; a < DEPTH; a++) wr_word(ADDR_W'(a), 16'(a * 16'h1111) ^ 16'hA5C3, 0, 0);
    for (int a = 0; a < DEPTH; a++) rd_word(ADDR_W'(a), 0, 0, "R4 fill");

    // R12 write attempted under reset is dropped
    @(negedge clk_i);
    rst_ni = 0;
    wr_word(ADDR_W'(3), 16'hDEAD, 0, 0);
    @(negedge clk_i);
    rst_ni = 1;
    rd_word(ADDR_W'(3), 0, 0, "R12 no write in reset");

    // R5 byte-masked writes
    for (int a = 0; a < DEPTH; a++)
      wr_word(ADDR_W'(a), 16'(~(a * 16'h0F0F)), (a % 2 == 0), (a % 2 == 1));
    for (int a = 0; a < DEPTH; a++) rd_word(ADDR_W'(a), 0, 0, "R5 masked");

    // R9 single-lane read gating
    for (int a = 0; a < DEPTH; a++) begin
      rd_word(ADDR_W'(a), 0, 1, "R9 lower only");
      rd_word(ADDR_W'(a), 1, 0, "R9 upper only");
    end

    // R10 address aliasing through high bits
    wr_word(ADDR_W'(DEPTH + 7) | (ADDR_W'(1) << 17), 16'h5AA5, 0, 0);
    rd_word(ADDR_W'(7), 0, 0, "R10 alias");
    chk("R10 alias value", 32'(rdata_o), 32'h5AA5);

    // R11 held write, changing data; R8 no drive despite out_en low
    @(negedge clk_i);
    sel_lo_ni = 0; sel_hi_i = 1; lane_lo_ni = 0; lane_hi_ni = 0;
    wr_ni = 0; out_en_ni = 0; addr_i = ADDR_W'(9);
    for (int k = 0; k < 4; k++) begin
      wdata_i = 16'h1234 + 16'(k * 16'h0101);
      #1;
      chk("R8 write no drive", 32'(lane_oe_o), 0);
      @(negedge clk_i);
    end
    wr_ni = 1;
    exp_mem[9] = 16'h1234 + 16'h0303;
    rd_word(ADDR_W'(9), 0, 0, "R11 last held");

    // control sweep of all 64 input combinations at one address
    for (int c = 0; c < 64; c++) begin
      logic s_lo, s_hi, l_lo, l_hi, w_n, o_n, on, wr, rd;
      string tag;
      {s_lo, s_hi, l_lo, l_hi, w_n, o_n} = 6'(c);
      @(negedge clk_i);
      sel_lo_ni = s_lo; sel_hi_i = s_hi; lane_lo_ni = l_lo; lane_hi_ni = l_hi;
      wr_ni = w_n; out_en_ni = o_n; addr_i = ADDR_W'(12); wdata_i = 16'h4000 + 16'(c * 16'h0103);
      on = !s_lo && s_hi && !(l_lo && l_hi);
      wr = on && !w_n;
      rd = on && w_n && !o_n;
      if (s_lo)             tag = "R1";
      else if (!s_hi)       tag = "R2";
      else if (l_lo && l_hi) tag = "R3";
      else if (!w_n)        tag = "R8";
      else if (o_n)         tag = "R7";
      else                  tag = "R6";
      #1;
      chk({tag, " sweep oe"}, 32'(lane_oe_o), rd ? 32'({!l_hi, !l_lo}) : 0);
      chk("R9 sweep data", 32'(rdata_o),
          rd ? 32'(exp_mem[12] & {{8{!l_hi}}, {8{!l_lo}}}) : 0);
      @(posedge clk_i);
      if (wr) begin
        if (!l_lo) exp_mem[12][7:0]  = wdata_i[7:0];
        if (!l_hi) exp_mem[12][15:8] = wdata_i[15:8];
      end
    end
    rd_word(ADDR_W'(12), 0, 0, "R3 sweep final contents");
    for (int a = 0; a < DEPTH; a++) rd_word(ADDR_W'(a), 0, 0, "R1 R2 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule